// File: doc/BRIEF.md
# Frame-Clock Ratio Detector

This block watches an already synchronized frame clock with the free-running system clock. It counts the system-clock cycles between consecutive rising edges of the frame clock. Each count is matched against a fixed, irregular table of supported oversampling ratios. The block reports the matched ratio as a 4-bit code, a locked flag once the measurement is stable, and a flag that marks a window whose length is not in the table.

A mode-select input asks for double-speed operation. While that request is raised, the two smallest ratios are not accepted. The speed output goes to double only when the block is locked onto a ratio of 128 or less while double speed is requested. Each match accepts a few cycles of error either way, so system clocks that are not exact multiples of the frame rate still classify. A frequency such as 25 MHz against a 48 kHz frame gives about 520 cycles per frame, which does not fall in any window and is therefore reported as unsupported.

Top module: `clk_ratio_detector`

## Requirements
- R1: After reset, ratio_code is 15, and locked, speed_dbl and unsupported are 0.
- R2: A window is the number of clk cycles from one rising edge of lrck_sync to the next. Codes 0 to 8 stand for the ratios 32, 64, 128, 192, 256, 384, 512, 768 and 1024 in that order. Code 15 means no ratio.
- R3: A window matches a ratio when it differs from that ratio by at most 2 cycles. A difference of 3 or more does not match.
- R4: locked rises after three consecutive completed windows classify to the same supported code. After only two such windows, locked stays 0.
- R5: While locked, one window that does not match the locked code leaves locked and ratio_code unchanged. Two consecutive non-matching windows clear locked and set ratio_code to 15. While unlocked, ratio_code is always 15.
- R6: If no rising edge of lrck_sync arrives for 2048 cycles, locked and unsupported go to 0 and ratio_code goes to 15.
- R7: unsupported is 1 exactly when the most recently completed window matched no allowed ratio.
- R8: While dbl_req is 1, windows near 32 or 64 are not allowed and classify as unsupported.
- R9: speed_dbl is 1 only when locked is 1, dbl_req is 1 and the locked ratio is at most 128. In every other case it is 0.
- R10: The first rising edge after reset or after a timeout only starts a window. The partial interval before it is never classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| lrck_sync | input | 1 | Frame clock, already synchronized to clk |
| dbl_req | input | 1 | Requests double-speed operation |
| ratio_code | output | 4 | Locked ratio code (0..8), 15 when not locked |
| speed_dbl | output | 1 | 1 = double speed, 0 = single speed |
| locked | output | 1 | Ratio measurement stable |
| unsupported | output | 1 | Last window matched no allowed ratio |

## Verification
The assertions rely on three assumptions:
- lrck_sync is already free of metastability and is sampled only at clk edges, so a rising edge is a single-cycle event.
- dbl_req holds steady for whole windows.
- The tolerance windows around the table entries do not overlap.

The stimulus drives lrck_sync and dbl_req only on the falling clock edge. It keeps each frame period constant over a run and changes dbl_req only while reset is held, with one exception: the mismatch and timeout tests vary the period between whole frames.

// File: rtl/crd_pkg.sv
package crd_pkg;
  localparam int CODE_W     = 4;
  localparam int N_RATIO    = 9;
  localparam int RATIO_W    = 16;
  localparam logic [CODE_W-1:0] UNSUP_CODE = 4'hF;
  localparam logic [CODE_W-1:0] CODE_128   = 4'd2;

  // Table entry idx: 32, 64, then alternating 128*2^k and 192*2^k.
  function automatic logic [RATIO_W-1:0] ratio_of(input int unsigned idx);
    logic [RATIO_W-1:0] r;
    if (idx == 0)           r = 16'd32;
    else if (idx == 1)      r = 16'd64;
    else if (idx[0] == 1'b0) r = 16'd128 << ((idx - 2) / 2);
    else                    r = 16'd192 << ((idx - 3) / 2);
    return r;
  endfunction

  // The two smallest ratios are single-speed only.
  function automatic logic ratio_allowed(input int unsigned idx, input logic dbl);
    return !(dbl && (idx < 2));
  endfunction
endpackage

// File: rtl/crd_window_meter.sv
module crd_window_meter #(
  parameter int TIMEOUT_CYC = 2048,
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lrck_sync,
  output logic             win_vld,
  output logic [CNT_W-1:0] win_cnt,
  output logic             timeout
);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic             lrck_d;
  logic             primed;
  logic [CNT_W-1:0] cnt;
  logic             rise;

  assign rise = lrck_sync & ~lrck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      lrck_d  <= 1'b0;
      primed  <= 1'b0;
      cnt     <= '0;
      win_vld <= 1'b0;
      win_cnt <= '0;
      timeout <= 1'b0;
    end else begin
      lrck_d <= lrck_sync;
      if (rise) begin
        win_cnt <= cnt;
        win_vld <= primed;
        primed  <= 1'b1;
        cnt     <= CNT_W'(1);
        timeout <= 1'b0;
      end else begin
        win_vld <= 1'b0;
        if (cnt == CNT_LAST) begin
          timeout <= 1'b1;
          primed  <= 1'b0;
          cnt     <= CNT_SAT;
        end else begin
          timeout <= 1'b0;
          if (cnt != CNT_SAT) cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // R10: the edge after a timeout only primes a new window
  a_r10_no_window_after_timeout: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !win_vld);
  // R2: a reported window never exceeds the timeout limit
  a_r2_window_in_range: assert property (@(posedge clk) disable iff (rst)
    win_vld |-> (win_cnt != '0) && (win_cnt < CNT_SAT));
endmodule

// File: rtl/crd_ratio_match.sv
module crd_ratio_match
  import crd_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int TOL   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_vld,
  input  logic [CNT_W-1:0]  win_cnt,
  input  logic              dbl_req,
  output logic              cls_vld,
  output logic [CODE_W-1:0] cls_code
);
  logic [RATIO_W-1:0] cnt_x;
  logic [N_RATIO-1:0] hit;
  logic [CODE_W-1:0]  code_c;

  assign cnt_x = RATIO_W'(win_cnt);

  for (genvar i = 0; i < N_RATIO; i++) begin : g_entry
    localparam logic [RATIO_W-1:0] LO = ratio_of(i) - RATIO_W'(TOL);
    localparam logic [RATIO_W-1:0] HI = ratio_of(i) + RATIO_W'(TOL);
    assign hit[i] = ratio_allowed(i, dbl_req) && (cnt_x >= LO) && (cnt_x <= HI);
  end

  always_comb begin
    code_c = UNSUP_CODE;
    for (int i = N_RATIO - 1; i >= 0; i--) begin
      if (hit[i]) code_c = CODE_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_vld  <= 1'b0;
      cls_code <= UNSUP_CODE;
    end else begin
      cls_vld <= win_vld;
      if (win_vld) cls_code <= code_c;
    end
  end

  // R3: tolerance windows never overlap, so at most one entry hits
  a_r3_single_hit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));
  // R8: with double speed requested, no window lands on code 0 or 1
  a_r8_low_ratio_masked: assert property (@(posedge clk) disable iff (rst)
    (win_vld && dbl_req) |=> (cls_code >= CODE_128));
endmodule

// File: rtl/crd_lock_track.sv
module crd_lock_track
  import crd_pkg::*;
#(
  parameter int LOCK_WIN = 3,
  parameter int DROP_WIN = 2,
  localparam int AG_W = $clog2(LOCK_WIN + 1),
  localparam int MS_W = $clog2(DROP_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [CODE_W-1:0] in_code,
  input  logic              timeout,
  input  logic              dbl_req,
  output logic [CODE_W-1:0] ratio_code,
  output logic              locked,
  output logic              unsupported,
  output logic              speed_dbl
);
  localparam logic [AG_W-1:0] AG_MAX = AG_W'(LOCK_WIN);
  localparam logic [MS_W-1:0] MS_MAX = MS_W'(DROP_WIN);

  logic [CODE_W-1:0] cand_q, cand_n, lcode_n;
  logic [AG_W-1:0]   agree_q, agree_n;
  logic [MS_W-1:0]   miss_q, miss_n;
  logic              lock_n, unsup_n, spd_n;

  always_comb begin
    cand_n  = cand_q;
    agree_n = agree_q;
    miss_n  = miss_q;
    lock_n  = locked;
    lcode_n = ratio_code;
    unsup_n = unsupported;
    if (timeout) begin
      cand_n  = UNSUP_CODE;
      agree_n = '0;
      miss_n  = '0;
      lock_n  = 1'b0;
      lcode_n = UNSUP_CODE;
      unsup_n = 1'b0;
    end else if (in_vld) begin
      unsup_n = (in_code == UNSUP_CODE);
      cand_n  = in_code;
      if (in_code != cand_q)    agree_n = AG_W'(1);
      else if (agree_q < AG_MAX) agree_n = agree_q + AG_W'(1);
      if (locked) begin
        if (in_code == ratio_code) begin
          miss_n = '0;
        end else if (miss_q + MS_W'(1) >= MS_MAX) begin
          miss_n  = '0;
          lock_n  = 1'b0;
          lcode_n = UNSUP_CODE;
        end else begin
          miss_n = miss_q + MS_W'(1);
        end
      end else if ((in_code != UNSUP_CODE) && (agree_n >= AG_MAX)) begin
        lock_n  = 1'b1;
        lcode_n = in_code;
        miss_n  = '0;
      end
    end
    spd_n = lock_n && dbl_req && (lcode_n <= CODE_128);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q      <= UNSUP_CODE;
      agree_q     <= '0;
      miss_q      <= '0;
      locked      <= 1'b0;
      ratio_code  <= UNSUP_CODE;
      unsupported <= 1'b0;
      speed_dbl   <= 1'b0;
    end else begin
      cand_q      <= cand_n;
      agree_q     <= agree_n;
      miss_q      <= miss_n;
      locked      <= lock_n;
      ratio_code  <= lcode_n;
      unsupported <= unsup_n;
      speed_dbl   <= spd_n;
    end
  end

  // R5: lock and a valid code go together
  a_r5_lock_code_pair: assert property (@(posedge clk) disable iff (rst)
    locked == (ratio_code != UNSUP_CODE));
  // R6: a timeout always clears lock
  a_r6_timeout_unlocks: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !locked);
  // R9: double speed only while locked at 128 or below
  a_r9_speed_needs_lock: assert property (@(posedge clk) disable iff (rst)
    speed_dbl |-> (locked && ratio_code <= CODE_128));
  // R4: lock is only gained on a classified window
  a_r4_lock_on_window: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(in_vld));
  // R7: the flag only changes on a window or a timeout
  a_r7_unsup_changes_on_event: assert property (@(posedge clk) disable iff (rst)
    !in_vld && !timeout |=> $stable(unsupported));
endmodule

// File: rtl/clk_ratio_detector.sv
module clk_ratio_detector
  import crd_pkg::*;
#(
  parameter int TIMEOUT_CYC = 2048,
  parameter int TOL         = 2,
  parameter int LOCK_WIN    = 3,
  parameter int DROP_WIN    = 2,
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lrck_sync,
  input  logic       dbl_req,
  output logic [3:0] ratio_code,
  output logic       speed_dbl,
  output logic       locked,
  output logic       unsupported
);
  logic              win_vld, timeout, cls_vld;
  logic [CNT_W-1:0]  win_cnt;
  logic [CODE_W-1:0] cls_code;

  crd_window_meter #(.TIMEOUT_CYC(TIMEOUT_CYC)) meter_i (
    .clk(clk), .rst(rst), .lrck_sync(lrck_sync),
    .win_vld(win_vld), .win_cnt(win_cnt), .timeout(timeout)
  );

  crd_ratio_match #(.CNT_W(CNT_W), .TOL(TOL)) match_i (
    .clk(clk), .rst(rst), .win_vld(win_vld), .win_cnt(win_cnt),
    .dbl_req(dbl_req), .cls_vld(cls_vld), .cls_code(cls_code)
  );

  crd_lock_track #(.LOCK_WIN(LOCK_WIN), .DROP_WIN(DROP_WIN)) track_i (
    .clk(clk), .rst(rst), .in_vld(cls_vld), .in_code(cls_code),
    .timeout(timeout), .dbl_req(dbl_req), .ratio_code(ratio_code),
    .locked(locked), .unsupported(unsupported), .speed_dbl(speed_dbl)
  );
endmodule

// File: tb/clk_ratio_detector_tb_top.sv
module clk_ratio_detector_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lrck = 1'b0;
  logic       dbl = 1'b0;
  logic [3:0] code;
  logic       spd, lck, uns;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  clk_ratio_detector dut_i (
    .clk(clk), .rst(rst), .lrck_sync(lrck), .dbl_req(dbl),
    .ratio_code(code), .speed_dbl(spd), .locked(lck), .unsupported(uns)
  );

  // period, dbl_req, expected code, locked, unsupported, speed
  localparam int NV = 17;
  localparam int VEC [NV][6] = '{
    '{256, 0,  4, 1, 0, 0}, '{258, 0,  4, 1, 0, 0}, '{254, 0,  4, 1, 0, 0},
    '{259, 0, 15, 0, 1, 0}, '{32,  0,  0, 1, 0, 0}, '{64,  0,  1, 1, 0, 0},
    '{64,  1, 15, 0, 1, 0}, '{32,  1, 15, 0, 1, 0}, '{128, 1,  2, 1, 0, 1},
    '{128, 0,  2, 1, 0, 0}, '{192, 0,  3, 1, 0, 0}, '{384, 1,  5, 1, 0, 0},
    '{512, 0,  6, 1, 0, 0}, '{768, 0,  7, 1, 0, 0}, '{1024, 0, 8, 1, 0, 0},
    '{1026, 0, 8, 1, 0, 0}, '{530, 0, 15, 0, 1, 0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    lrck = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic frames(input int p, input int n);
    for (int k = 0; k < n; k++) begin
      lrck = 1'b1;
      repeat (p / 2) @(negedge clk);
      lrck = 1'b0;
      repeat (p - p / 2) @(negedge clk);
    end
  endtask

  task automatic expect_all(input string req, input int c, input int l, input int u, input int s);
    chk({req, " code"}, int'(code), c);
    chk({req, " locked"}, int'(lck), l);
    chk({req, " unsupported"}, int'(uns), u);
    chk({req, " speed"}, int'(spd), s);
  endtask

  initial begin
    // R1: reset state
    do_reset();
    expect_all("R1", 15, 0, 0, 0);

    // R2 R3 R7 R8 R9: table walk, five completed windows per vector
    for (int v = 0; v < NV; v++) begin
      dbl = VEC[v][1][0];
      do_reset();
      frames(VEC[v][0], 6);
      expect_all("R2/R3/R8/R9 vector", VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
    end
    dbl = 1'b0;

    // R4: two windows do not lock, the third does
    do_reset();
    frames(256, 3);
    chk("R4 two windows", int'(lck), 0);
    frames(256, 1);
    chk("R4 three windows", int'(lck), 1);
    chk("R4 code", int'(code), 4);

    // R5: one mismatch tolerated, two drop the lock
    frames(256, 2);
    frames(512, 1);
    frames(256, 1);
    chk("R5 one miss locked", int'(lck), 1);
    chk("R5 one miss code", int'(code), 4);
    frames(256, 1);
    frames(512, 2);
    frames(256, 1);
    chk("R5 two misses locked", int'(lck), 0);
    chk("R5 two misses code", int'(code), 15);

    // R7: unsupported window while locked sets the flag only
    do_reset();
    frames(256, 5);
    frames(300, 1);
    frames(256, 1);
    chk("R7 flag", int'(uns), 1);
    chk("R7 still locked", int'(lck), 1);
    frames(256, 1);
    chk("R7 flag clears", int'(uns), 0);

    // R6: timeout drops lock and clears flags
    frames(300, 1);
    frames(256, 1);
    repeat (2100) @(negedge clk);
    chk("R6 locked", int'(lck), 0);
    chk("R6 code", int'(code), 15);
    chk("R6 unsupported", int'(uns), 0);

    // R10: first edge after timeout only primes
    frames(256, 3);
    chk("R10 primed only", int'(lck), 0);
    frames(256, 1);
    chk("R10 relock", int'(lck), 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule